// File: doc/BRIEF.md
# Express Starvation Throttle

This block keeps express traffic from locking normal traffic out of an output at a router that express flits pass straight through. It has two halves that sit at different nodes and are joined only by a one-bit token wire. The watch half sits at the pass-through node. It counts back-to-back cycles in which a normal flit is waiting, is not granted, and an express flit holds the output. When that run reaches `N_STARVE` cycles, it raises a one-cycle token towards the node that injects the express traffic.

The gate half sits at the injecting node. When a token arrives, it drops an express-enable output for `P_BLOCK` cycles. While that output is low, the express source holds back any new express flit.

The watch half is a four-state machine: `DET_IDLE`, `DET_COUNT`, `DET_FIRE` and `DET_HOLD`.

- `DET_IDLE` moves to `DET_COUNT` on a starved cycle. If `N_STARVE` is 1 it moves straight to `DET_FIRE`.
- `DET_COUNT` moves back to `DET_IDLE` on any cycle that is not starved. It moves to `DET_FIRE` on the `N_STARVE`-th starved cycle in a row.
- `DET_FIRE` lasts one cycle and always moves to `DET_HOLD`.
- `DET_HOLD` returns to `DET_IDLE` after `P_BLOCK` cycles.

The gate half is a two-state machine: `GATE_OPEN` and `GATE_BLOCKED`.

- `GATE_OPEN` moves to `GATE_BLOCKED` when the token is sampled.
- `GATE_BLOCKED` reloads its window when another token is sampled. It moves back to `GATE_OPEN` when its window runs out.

Top module: `starve_throttle`

## Requirements
- R1: While reset is held, and in the first cycle after it, `token_o` is 0 and `exp_enable_o` is 1.
- R2: A starved cycle is one in which `nrm_pending_i`=1, `nrm_grant_i`=0 and `exp_active_i`=1. After `N_STARVE` starved cycles in a row, `token_o` is 1 in the cycle that follows the last of them.
- R3: A cycle with `nrm_grant_i`=1 or `nrm_pending_i`=0 clears the starvation run. A token then needs `N_STARVE` fresh starved cycles.
- R4: A cycle with a normal flit waiting but `exp_active_i`=0 also clears the starvation run.
- R5: `token_o` is never high for two cycles in a row.
- R6: After a token, starved cycles are ignored for `P_BLOCK` cycles. Counting restarts from zero in the cycle after that hold. Under continuous starvation, tokens therefore repeat every `N_STARVE+P_BLOCK+1` cycles.
- R7: When `token_i`=1 is sampled, `exp_enable_o` is 0 for exactly `P_BLOCK` cycles, starting in the next cycle. It then returns to 1.
- R8: A token sampled while `exp_enable_o` is 0 restarts the window. `exp_enable_o` then stays 0 for `P_BLOCK` cycles after that later token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nrm_pending_i | input | 1 | A normal flit waits for the output |
| nrm_grant_i | input | 1 | The waiting normal flit won the output this cycle |
| exp_active_i | input | 1 | An express flit holds the output this cycle |
| token_o | output | 1 | One-cycle starvation token sent upstream |
| token_i | input | 1 | Starvation token received from downstream |
| exp_enable_o | output | 1 | Express injection allowed when 1 |

## Verification
The bench interrupts starvation runs one cycle short of `N_STARVE`, once with a grant, once with the request dropped and once with the express side idle. A design that keeps the count across such a break would raise a token early.

Continuous starvation checks the token period exactly. A hold that is one cycle short would shorten the period, and a token that is not cleared would be two cycles wide.

On the gate side, a single token checks the window length on both edges. A second token arriving mid-window separates a window that restarts from one that merely runs out. Overlapping traffic on both halves shows that neither half disturbs the other.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

    typedef enum logic [1:0] {
        DET_IDLE,
        DET_COUNT,
        DET_FIRE,
        DET_HOLD
    } det_state_t;

    typedef enum logic {
        GATE_OPEN,
        GATE_BLOCKED
    } gate_state_t;

endpackage

// File: rtl/starve_detect.sv
module starve_detect
    import throttle_pkg::*;
#(
    parameter int N_STARVE = 4,
    parameter int P_BLOCK  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic starved_i,
    output logic token_o
);
    localparam int CNT_W = $clog2(N_STARVE + 1);
    localparam int HLD_W = $clog2(P_BLOCK + 1);
    localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(N_STARVE - 1);
    localparam logic [HLD_W-1:0] HOLD_LEN = HLD_W'(P_BLOCK);

    det_state_t       state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic [HLD_W-1:0] hold_q, hold_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DET_IDLE;
            run_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            hold_q  <= hold_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        hold_d  = hold_q;
        unique case (state_q)
            DET_IDLE, DET_COUNT: begin
                if (!starved_i) begin
                    state_d = DET_IDLE;
                    run_d   = '0;
                end else if (run_q == RUN_LAST) begin
                    state_d = DET_FIRE;
                    run_d   = '0;
                end else begin
                    state_d = DET_COUNT;
                    run_d   = run_q + 1'b1;
                end
            end
            DET_FIRE: begin
                state_d = DET_HOLD;
                hold_d  = HOLD_LEN;
            end
            DET_HOLD: begin
                if (hold_q == HLD_W'(1)) begin
                    state_d = DET_IDLE;
                    hold_d  = '0;
                end else begin
                    hold_d = hold_q - 1'b1;
                end
            end
            default: begin
                state_d = DET_IDLE;
                run_d   = '0;
                hold_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        token_o = (state_q == DET_FIRE);
    end

endmodule

// File: rtl/window_gate.sv
module window_gate
    import throttle_pkg::*;
#(
    parameter int P_BLOCK = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic token_i,
    output logic exp_enable_o
);
    localparam int WIN_W = $clog2(P_BLOCK + 1);
    localparam logic [WIN_W-1:0] WIN_LEN = WIN_W'(P_BLOCK);

    gate_state_t      state_q, state_d;
    logic [WIN_W-1:0] left_q, left_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        unique case (state_q)
            GATE_OPEN: begin
                if (token_i) begin
                    state_d = GATE_BLOCKED;
                    left_d  = WIN_LEN;
                end
            end
            GATE_BLOCKED: begin
                if (token_i) begin
                    left_d = WIN_LEN;
                end else if (left_q == WIN_W'(1)) begin
                    state_d = GATE_OPEN;
                    left_d  = '0;
                end else begin
                    left_d = left_q - 1'b1;
                end
            end
            default: begin
                state_d = GATE_OPEN;
                left_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        exp_enable_o = (state_q == GATE_OPEN);
    end

endmodule

// File: rtl/starve_throttle.sv
module starve_throttle #(
    parameter int N_STARVE = 4,
    parameter int P_BLOCK  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nrm_pending_i,
    input  logic nrm_grant_i,
    input  logic exp_active_i,
    output logic token_o,
    input  logic token_i,
    output logic exp_enable_o
);
    logic starved;

    always_comb begin
        starved = nrm_pending_i && !nrm_grant_i && exp_active_i;
    end

    starve_detect #(
        .N_STARVE(N_STARVE),
        .P_BLOCK (P_BLOCK)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .starved_i(starved),
        .token_o  (token_o)
    );

    window_gate #(
        .P_BLOCK(P_BLOCK)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .token_i     (token_i),
        .exp_enable_o(exp_enable_o)
    );

endmodule

// File: rtl/starve_throttle_chk.sv
module starve_throttle_chk #(
    parameter int N_STARVE = 4,
    parameter int P_BLOCK  = 6
) (
    input logic clk,
    input logic rst_n,
    input logic nrm_pending_i,
    input logic nrm_grant_i,
    input logic exp_active_i,
    input logic token_o,
    input logic token_i,
    input logic exp_enable_o
);
    int unsigned win_left;
    int unsigned quiet_left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_left   <= 0;
            quiet_left <= 0;
        end else begin
            if (token_i)
                win_left <= P_BLOCK;
            else if (win_left != 0)
                win_left <= win_left - 1;
            if (token_o)
                quiet_left <= P_BLOCK;
            else if (quiet_left != 0)
                quiet_left <= quiet_left - 1;
        end
    end

    // R5
    token_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        token_o |=> !token_o);

    // R2
    token_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!nrm_pending_i || nrm_grant_i || !exp_active_i) |=> !token_o);

    // R6
    holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        token_o |-> (quiet_left == 0));

    // R7
    block_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        token_i |=> !exp_enable_o);

    // R8
    window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_enable_o == (win_left == 0));

endmodule

bind starve_throttle starve_throttle_chk #(
    .N_STARVE(N_STARVE),
    .P_BLOCK (P_BLOCK)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .nrm_pending_i(nrm_pending_i),
    .nrm_grant_i  (nrm_grant_i),
    .exp_active_i (exp_active_i),
    .token_o      (token_o),
    .token_i      (token_i),
    .exp_enable_o (exp_enable_o)
);

// File: tb/starve_throttle_tb.sv
`timescale 1ns/1ps
module starve_throttle_tb;
    localparam int N = 3;
    localparam int P = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pend = 1'b0, grant = 1'b0, xact = 1'b0, tok_in = 1'b0;
    logic tok_out, exp_en;

    always #5 clk = ~clk;

    starve_throttle #(.N_STARVE(N), .P_BLOCK(P)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .nrm_pending_i(pend),
        .nrm_grant_i  (grant),
        .exp_active_i (xact),
        .token_o      (tok_out),
        .token_i      (tok_in),
        .exp_enable_o (exp_en)
    );

    typedef struct {
        logic  tok;
        logic  en;
        string tag;
    } exp_t;

    exp_t queue_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    string cur_tag = "R1";

    // reference model state, in requirement terms
    int streak = 0;
    int quiet = 0;
    int blk = 0;

    task automatic cyc(input logic p, input logic g, input logic x, input logic t);
        exp_t e;
        logic tok_next;
        @(negedge clk);
        pend = p; grant = g; xact = x; tok_in = t;
        tok_next = 1'b0;
        if (quiet > 0) begin
            quiet--;
            streak = 0;
        end else if (p && !g && x) begin
            streak++;
            if (streak == N) begin
                tok_next = 1'b1;
                streak = 0;
                quiet = P + 1;
            end
        end else begin
            streak = 0;
        end
        if (t) blk = P;
        else if (blk > 0) blk--;
        e.tok = tok_next;
        e.en  = (blk == 0);
        e.tag = cur_tag;
        queue_q.push_back(e);
    endtask

    task automatic starve(input int k);
        for (int i = 0; i < k; i++) cyc(1, 0, 1, 0);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) cyc(0, 0, 0, 0);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (rst_n && queue_q.size() > 0) begin
            exp_t e;
            e = queue_q.pop_front();
            checks++;
            if (tok_out !== e.tok) begin
                errors++;
                $display("FAIL %s token_o actual %b expected %b at %0t", e.tag, tok_out, e.tok, $time);
            end
            checks++;
            if (exp_en !== e.en) begin
                errors++;
                $display("FAIL %s exp_enable_o actual %b expected %b at %0t", e.tag, exp_en, e.en, $time);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (tok_out !== 1'b0 || exp_en !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset outputs actual %b%b expected 01", tok_out, exp_en);
        end
        rst_n = 1'b1;
        cur_tag = "R1";
        idle(2);
        cur_tag = "R2";
        starve(N);
        idle(P + 3);
        cur_tag = "R3";
        starve(N - 1); cyc(1, 1, 1, 0);
        starve(N - 1); cyc(0, 0, 1, 0);
        starve(N);
        idle(P + 3);
        cur_tag = "R4";
        starve(N - 1); cyc(1, 0, 0, 0);
        starve(N - 1); cyc(1, 0, 0, 0);
        starve(N);
        idle(P + 3);
        cur_tag = "R5";
        starve(N + 2);
        cur_tag = "R6";
        starve(3 * (N + P + 1) + 2);
        idle(P + 3);
        cur_tag = "R7";
        cyc(0, 0, 0, 1);
        idle(P + 3);
        cur_tag = "R8";
        cyc(0, 0, 0, 1);
        idle(2);
        cyc(0, 0, 0, 1);
        idle(P - 1);
        cyc(0, 0, 0, 1);
        idle(P + 3);
        cur_tag = "R7";
        for (int i = 0; i < 2 * (N + P + 1); i++) cyc(1, 0, 1, (i % 7) == 0);
        idle(P + 3);
        @(posedge clk);
        #4;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule